// File: doc/BRIEF.md
# Microcontroller Reset Sequencer

This block generates the internal system reset of a small 8-bit microcontroller core whose machine cycle is six oscillator clocks. It merges four requests into one reset line. The first is the external reset pin, which is synchronized and then qualified so that only a sustained high level takes effect. The second is a power-on detect strobe. The third is a watchdog overflow strobe, which acts only when its enable is set. The fourth is a software reset bit in an auxiliary control register.

Power-on, watchdog and software requests are stretched into fixed pulses of three machine cycles. The pin-driven reset follows the qualified pin and is extended by one machine cycle after release. A 2-bit cause field tells firmware which source started the most recent reset. All lengths are parameters expressed in machine cycles and converted to oscillator clocks inside the block.

Top module: `mcu_rst_seq`

## Requirements
- R1: After `rst_ni` is released, `sys_rst_o` is 0, `aux_srst_o` is 0 and `cause_o` reads 2'b01 (power-on).
- R2: `rst_pin_i` passes two synchronizer flops. If it is sampled high on fewer than 12 consecutive clock edges, no reset results. If it is sampled high on 12 or more, `sys_rst_o` is seen high after the 14th edge, counting the first high sample as edge 0.
- R3: A qualified pin reset stays high while the pin is high and falls 8 clock edges after the first low sample of the pin (2 sync stages plus one machine cycle). A pin pulse of N samples, with N at least 12, therefore gives N-6 reset clocks.
- R4: A `wdt_ovf_i` strobe sampled together with `wdt_en_i`=1 drives `sys_rst_o` high for exactly 18 clocks, starting after that edge. With `wdt_en_i`=0 the strobe has no effect.
- R5: The watchdog pulse is independent of the pin. Its length is unchanged while the pin carries an unqualified high level.
- R6: A `por_i` strobe drives `sys_rst_o` high for 18 clocks, starting after the sampling edge.
- R7: A register write with bit 5 of `reg_wdata_i` set raises `aux_srst_o` after that edge. One edge later, `sys_rst_o` rises for 18 clocks and `aux_srst_o` clears. A write with bit 5 clear changes neither output.
- R8: `cause_o` is loaded on the edge where a reset source starts: 2'b00 pin, 2'b01 power-on, 2'b10 watchdog, 2'b11 software.
- R9: When several sources start on the same edge, `cause_o` takes the first of: power-on, watchdog, software, pin.
- R10: A new watchdog or power-on strobe during an active pulse restarts its 18-clock count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the sequencer itself |
| rst_pin_i | input | 1 | External reset pin level (asynchronous) |
| por_i | input | 1 | Power-on detect strobe |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| wdt_en_i | input | 1 | Enables watchdog overflow as a reset source |
| reg_wr_i | input | 1 | Auxiliary control register write strobe |
| reg_wdata_i | input | 8 | Write data; bit 5 requests software reset |
| sys_rst_o | output | 1 | Internal system reset, active high |
| aux_srst_o | output | 1 | Current value of the self-clearing software reset bit |
| cause_o | output | 2 | Source of the most recent reset |

## Verification
The bench builds the block with its default parameters: 6 clocks per machine cycle, 2 machine cycles of pin qualification, 3-cycle pulses and a 1-cycle release extension. With these values the 11- and 12-sample pin thresholds, the exact 18-clock pulses and the 8-clock release delay all fit into short windows. Pulse counts can therefore be measured edge by edge. Random pin lengths up to 30 samples straddle the threshold many times. Random register data exercises bit 5 against the other bits. Directed cases line up sources on one edge to check the cause priority.

// File: rtl/mcu_rst_pkg.sv
package mcu_rst_pkg;
  typedef enum logic [1:0] {
    CAUSE_PIN = 2'b00,
    CAUSE_POR = 2'b01,
    CAUSE_WDT = 2'b10,
    CAUSE_SW  = 2'b11
  } rst_cause_e;

  localparam int unsigned SRST_BIT = 5;

  // pulse source slots, also cause priority order
  localparam int unsigned SRC_POR = 0;
  localparam int unsigned SRC_WDT = 1;
  localparam int unsigned SRC_SW  = 2;
  localparam int unsigned NUM_PULSE_SRC = 3;
endpackage

// File: rtl/mcu_rst_pin_filter.sv
module mcu_rst_pin_filter #(
  parameter int unsigned QUAL_CLK = 12,
  parameter int unsigned HOLD_CLK = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic start_o,
  output logic pin_rst_o
);
  localparam int unsigned QW = $clog2(QUAL_CLK + 1);
  localparam int unsigned HW = $clog2(HOLD_CLK + 1);

  logic [1:0]    sync_q;
  logic [QW-1:0] qcnt_q;
  logic [HW-1:0] hold_q;
  logic          pin_s, qual;

  assign pin_s = sync_q[1];
  assign qual  = (qcnt_q == QW'(QUAL_CLK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     qcnt_q <= '0;
    else if (!pin_s) qcnt_q <= '0;
    else if (!qual)  qcnt_q <= qcnt_q + 1'b1;
  end

  // hold reloads while qualified, runs out one machine cycle after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            hold_q <= '0;
    else if (qual)          hold_q <= HW'(HOLD_CLK);
    else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
  end

  assign start_o   = qual && (hold_q == '0);
  assign pin_rst_o = (hold_q != '0);

  assert_pin_qualified_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_rst_o) |-> $past(qcnt_q) == QW'(QUAL_CLK));
endmodule

// File: rtl/mcu_rst_pulse_gen.sv
module mcu_rst_pulse_gen #(
  parameter int unsigned LEN_CLK = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(LEN_CLK + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (trig_i)       cnt_q <= CW'(LEN_CLK);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  assert_retrigger_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> active_o);
endmodule

// File: rtl/mcu_rst_aux_reg.sv
module mcu_rst_aux_reg
  import mcu_rst_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             clr_i,
  output logic             srst_o
);
  logic srst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        srst_q <= 1'b0;
    else if (wr_i && wdata_i[SRST_BIT]) srst_q <= 1'b1;
    else if (clr_i)                     srst_q <= 1'b0;
  end

  assign srst_o = srst_q;

  assert_srst_self_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_q && !(wr_i && wdata_i[SRST_BIT])) |=> !srst_q);
endmodule

// File: rtl/mcu_rst_seq.sv
module mcu_rst_seq
  import mcu_rst_pkg::*;
#(
  parameter int unsigned OSC_PER_MC  = 6,
  parameter int unsigned PIN_QUAL_MC = 2,
  parameter int unsigned PULSE_MC    = 3,
  parameter int unsigned HOLD_MC     = 1,
  parameter int unsigned REG_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rst_pin_i,
  input  logic             por_i,
  input  logic             wdt_ovf_i,
  input  logic             wdt_en_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic             sys_rst_o,
  output logic             aux_srst_o,
  output logic [1:0]       cause_o
);
  localparam int unsigned QUAL_CLK  = PIN_QUAL_MC * OSC_PER_MC;
  localparam int unsigned PULSE_CLK = PULSE_MC * OSC_PER_MC;
  localparam int unsigned HOLD_CLK  = HOLD_MC * OSC_PER_MC;

  logic [NUM_PULSE_SRC-1:0] trig, active;
  logic                     pin_start, pin_rst, srst;
  rst_cause_e               cause_q;

  mcu_rst_pin_filter #(.QUAL_CLK(QUAL_CLK), .HOLD_CLK(HOLD_CLK)) u_pin (
    .clk_i, .rst_ni, .pin_i(rst_pin_i), .start_o(pin_start), .pin_rst_o(pin_rst)
  );

  mcu_rst_aux_reg #(.REG_W(REG_W)) u_aux (
    .clk_i, .rst_ni, .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .clr_i(trig[SRC_SW]), .srst_o(srst)
  );

  assign trig[SRC_POR] = por_i;
  assign trig[SRC_WDT] = wdt_ovf_i & wdt_en_i;
  assign trig[SRC_SW]  = srst;

  for (genvar g = 0; g < NUM_PULSE_SRC; g++) begin : g_pulse
    mcu_rst_pulse_gen #(.LEN_CLK(PULSE_CLK)) u_gen (
      .clk_i, .rst_ni, .trig_i(trig[g]), .active_o(active[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cause_q <= CAUSE_POR;
    else if (trig[SRC_POR])  cause_q <= CAUSE_POR;
    else if (trig[SRC_WDT])  cause_q <= CAUSE_WDT;
    else if (trig[SRC_SW])   cause_q <= CAUSE_SW;
    else if (pin_start)      cause_q <= CAUSE_PIN;
  end

  assign sys_rst_o  = (|active) | pin_rst;
  assign aux_srst_o = srst;
  assign cause_o    = cause_q;

  assert_por_priority_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (sys_rst_o && cause_o == CAUSE_POR));

  assert_wdt_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_ovf_i && wdt_en_i && !por_i) |=> (sys_rst_o && cause_o == CAUSE_WDT));
endmodule

// File: tb/mcu_rst_seq_test.sv
module mcu_rst_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC  = 2;
  localparam int QUAL  = 12;
  localparam int HOLD  = 6;
  localparam int PULSE = 18;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rst_pin_i = 0, por_i = 0, wdt_ovf_i = 0, wdt_en_i = 0, reg_wr_i = 0;
  logic [7:0] reg_wdata_i = '0;
  logic sys_rst_o, aux_srst_o;
  logic [1:0] cause_o;

  int checks = 0, errors = 0;
  logic [1:0] exp_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcu_rst_seq uut (
    .clk_i(clk), .rst_ni, .rst_pin_i, .por_i, .wdt_ovf_i, .wdt_en_i,
    .reg_wr_i, .reg_wdata_i, .sys_rst_o, .aux_srst_o, .cause_o
  );

  function automatic int exp_pin_cnt(int n);
    return (n >= QUAL) ? n + HOLD - QUAL : 0;
  endfunction

  function automatic int exp_pin_rise(int n);
    return (n >= QUAL) ? SYNC + QUAL : -1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge with all stimulus idle; edge 0 is the next posedge
  task automatic run_case(input int pin_len, input bit wdt0, input bit en, input int wdt2,
                          input bit por0, input bit wr0, input logic [7:0] wd, input int win,
                          output int rise, output int cnt, output int aux0, output int aux1);
    rst_pin_i = (pin_len > 0); wdt_ovf_i = wdt0; wdt_en_i = en; por_i = por0;
    reg_wr_i = wr0; reg_wdata_i = wd;
    rise = -1; cnt = 0; aux0 = 0; aux1 = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (sys_rst_o) begin cnt++; if (rise < 0) rise = k; end
      if (k == 0) aux0 = int'(aux_srst_o);
      if (k == 1) aux1 = int'(aux_srst_o);
      rst_pin_i = (k + 1 < pin_len); wdt_ovf_i = (k + 1 == wdt2);
      por_i = 0; reg_wr_i = 0; reg_wdata_i = '0;
    end
    wdt_en_i = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int rise, cnt, a0, a1, r;
    r = $urandom(32'h00c0ffee);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 sys_rst", int'(sys_rst_o), 0);
    check("R1 cause", int'(cause_o), 1);
    check("R1 aux_srst", int'(aux_srst_o), 0);
    exp_cause = 2'b01;

    run_case(11, 0, 0, -1, 0, 0, 8'h00, 40, rise, cnt, a0, a1);
    check("R2 short pin count", cnt, 0);
    check("R2 short pin cause", int'(cause_o), int'(exp_cause));

    run_case(12, 0, 0, -1, 0, 0, 8'h00, 40, rise, cnt, a0, a1);
    check("R2 min pin rise", rise, 14);
    check("R3 min pin count", cnt, 6);
    check("R8 pin cause", int'(cause_o), 0);
    exp_cause = 2'b00;

    run_case(25, 0, 0, -1, 0, 0, 8'h00, 50, rise, cnt, a0, a1);
    check("R3 long pin count", cnt, 19);

    run_case(0, 1, 0, -1, 0, 0, 8'h00, 30, rise, cnt, a0, a1);
    check("R4 disabled wdt count", cnt, 0);
    check("R4 disabled wdt cause", int'(cause_o), int'(exp_cause));

    run_case(0, 1, 1, -1, 0, 0, 8'h00, 30, rise, cnt, a0, a1);
    check("R4 wdt rise", rise, 0);
    check("R4 wdt count", cnt, PULSE);
    check("R8 wdt cause", int'(cause_o), 2);

    run_case(6, 1, 1, -1, 0, 0, 8'h00, 30, rise, cnt, a0, a1);
    check("R5 wdt with pin count", cnt, PULSE);

    run_case(0, 0, 0, -1, 1, 0, 8'h00, 30, rise, cnt, a0, a1);
    check("R6 por rise", rise, 0);
    check("R6 por count", cnt, PULSE);
    check("R8 por cause", int'(cause_o), 1);

    run_case(0, 1, 1, 0, 0, 0, 8'h00, 30, rise, cnt, a0, a1);
    check("R9 wdt cause before por", int'(cause_o), 2);
    run_case(0, 1, 1, -1, 1, 0, 8'h00, 30, rise, cnt, a0, a1);
    check("R9 por over wdt cause", int'(cause_o), 1);

    run_case(0, 0, 0, -1, 0, 1, 8'h20, 30, rise, cnt, a0, a1);
    check("R7 srst set", a0, 1);
    check("R7 srst cleared", a1, 0);
    check("R7 sw rise", rise, 1);
    check("R7 sw count", cnt, PULSE);
    check("R8 sw cause", int'(cause_o), 3);

    run_case(0, 0, 0, -1, 0, 1, 8'hdf, 30, rise, cnt, a0, a1);
    check("R7 bit5 clear count", cnt, 0);
    check("R7 bit5 clear srst", a0, 0);
    check("R7 bit5 clear cause", int'(cause_o), 3);

    run_case(0, 0, 1, 1, 0, 1, 8'h20, 30, rise, cnt, a0, a1);
    check("R9 wdt over sw rise", rise, 1);
    check("R9 wdt over sw cause", int'(cause_o), 2);

    run_case(14, 0, 1, 14, 0, 0, 8'h00, 40, rise, cnt, a0, a1);
    check("R9 wdt over pin cause", int'(cause_o), 2);

    run_case(0, 1, 1, 10, 0, 0, 8'h00, 40, rise, cnt, a0, a1);
    check("R10 retrigger count", cnt, 10 + PULSE);
    exp_cause = 2'b10;

    for (int i = 0; i < 40; i++) begin
      int kind, n;
      logic [7:0] d;
      bit en;
      kind = int'($urandom_range(2, 0));
      if (kind == 0) begin
        n = int'($urandom_range(30, 1));
        run_case(n, 0, 0, -1, 0, 0, 8'h00, n + 20, rise, cnt, a0, a1);
        check("R2 random pin rise", rise, exp_pin_rise(n));
        check("R3 random pin count", cnt, exp_pin_cnt(n));
        if (n >= QUAL) exp_cause = 2'b00;
      end else if (kind == 1) begin
        en = 1'($urandom_range(1, 0));
        run_case(0, 1, en, -1, 0, 0, 8'h00, 30, rise, cnt, a0, a1);
        check("R4 random wdt count", cnt, en ? PULSE : 0);
        if (en) exp_cause = 2'b10;
      end else begin
        d = 8'($urandom_range(255, 0));
        run_case(0, 0, 0, -1, 0, 1, d, 30, rise, cnt, a0, a1);
        check("R7 random sw count", cnt, d[5] ? PULSE : 0);
        if (d[5]) exp_cause = 2'b11;
      end
      check("R8 random cause", int'(cause_o), int'(exp_cause));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule